// File: doc/BRIEF.md
# Interleaved Low-Toggle Shift Register

This block is a serial delay line of fixed total length. Its input-to-output behaviour is that of a plain single chain of flip-flops. The storage is split into a number of interleaved lanes, set by a parameter. Each lane takes every lane-count-th input bit and shifts only on its own turn, so every storage flop changes state at most once per lane-count cycles. A small phase counter, running on the full-rate clock, picks which lane captures on each cycle. A full-rate output selector then reads the tails of the lanes in turn, which rebuilds the original bit order.

The lane count may be 1, 2 or 4, with a total length of 16. Each lane therefore holds 16, 8 or 4 bits. Lanes are clock-enabled flops on the one clock, so the design has a single clock domain. The asynchronous active-low reset is released through a two-flop synchronizer.

Top module: `ilv_shift_reg`

## Requirements
- R1: While rst_n is low, ser_out is 0 and all storage is cleared, with no clock edge needed.
- R2: Reset release is synchronized. The ser_in values at the first two rising edges after rst_n rises are not captured. Capture starts at the third edge.
- R3: With WAYS=1, ser_out after capture edge k equals the ser_in value captured at edge k-15. This is the output of a plain 16-stage chain, whose cleared stages read 0.
- R4: With WAYS=2, ser_out follows the same 16-stage chain behaviour cycle for cycle.
- R5: With WAYS=4, ser_out follows the same 16-stage chain behaviour cycle for cycle.
- R6: The phase counter is 0 after reset. It advances by one on every edge and wraps from WAYS-1 to 0, so an isolated 1 on ser_in appears exactly 16 edges later at every phase alignment.
- R7: Exactly one lane is enabled per cycle. Every other lane holds its contents, so each storage flop updates at most once every WAYS cycles.
- R8: The enabled lane loads the current ser_in into its head stage, and its other stages each move one place towards the tail.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Full-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ser_in | input | 1 | Serial data in |
| ser_out | output | 1 | Serial data out, delayed by the total length |

## Verification
The in-line properties check, on every cycle, the mechanics of the split chain. They cover the modulo stepping of the phase counter, the one-hot lane enable, idle lanes holding still, and the head of the active lane loading ser_in. The end-to-end claim is that the rebuilt stream matches a single 16-stage chain for each lane count. Only the bench scenarios can show that claim, because they compare against an independent chain model. The same holds for the behaviour around reset: the asynchronous clear under a full load, and the two swallowed edges at release.

// File: rtl/ilv_shift_pkg.sv
package ilv_shift_pkg;
  // Width of a counter that counts 0..ways-1, never less than one bit.
  function automatic int phase_width(input int ways);
    return (ways > 1) ? $clog2(ways) : 1;
  endfunction
endpackage

// File: rtl/ilv_rst_sync.sv
module ilv_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_sync_n = hold_q;
endmodule

// File: rtl/ilv_phase_ctr.sv
module ilv_phase_ctr #(
  parameter int WAYS = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic [ilv_shift_pkg::phase_width(WAYS)-1:0] phase,
  output logic [WAYS-1:0] lane_en
);
  localparam int PH_W = ilv_shift_pkg::phase_width(WAYS);
  localparam logic [PH_W-1:0] LAST = PH_W'(WAYS - 1);

  logic [PH_W-1:0] phase_q;
  logic [PH_W-1:0] phase_d;

  always_comb begin
    if (phase_q == LAST) phase_d = '0;
    else                 phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_en
    assign lane_en[g] = (phase_q == PH_W'(g));
  end

  assign phase = phase_q;

  // R6: wrap from the last phase back to zero
  p_phase_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == LAST) |=> (phase_q == '0));
  // R6: step by one below the last phase
  p_phase_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != LAST) |=> (phase_q == $past(phase_q) + 1'b1));
endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
  parameter int LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic tail
);
  logic [LEN-1:0] stage_q;
  logic [LEN-1:0] stage_d;

  always_comb begin
    stage_d = stage_q;
    if (en) begin
      stage_d[0] = din;
      for (int i = 1; i < LEN; i++) stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  assign tail = stage_q[LEN-1];

  // R7: an idle lane keeps every stage
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(stage_q));
  // R8: an enabled lane takes the serial input at its head
  p_head_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (stage_q[0] == $past(din)));
endmodule

// File: rtl/ilv_shift_reg.sv
module ilv_shift_reg #(
  parameter int WAYS  = 2,
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_in,
  output logic ser_out
);
  localparam int LEN  = DEPTH / WAYS;
  localparam int PH_W = ilv_shift_pkg::phase_width(WAYS);

  logic            rst_int_n;
  logic [PH_W-1:0] phase;
  logic [WAYS-1:0] lane_en;
  logic [WAYS-1:0] tails;

  ilv_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  ilv_phase_ctr #(.WAYS(WAYS)) u_phase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .phase   (phase),
    .lane_en (lane_en)
  );

  for (genvar g = 0; g < WAYS; g++) begin : g_lane
    ilv_lane #(.LEN(LEN)) u_lane (
      .clk   (clk),
      .rst_n (rst_int_n),
      .en    (lane_en[g]),
      .din   (ser_in),
      .tail  (tails[g])
    );
  end

  // Full-rate selector: the lane due to shift next holds the oldest bit.
  always_comb begin
    ser_out = 1'b0;
    for (int i = 0; i < WAYS; i++) begin
      if (phase == PH_W'(i)) ser_out = tails[i];
    end
  end

  // R7: exactly one lane captures per cycle
  p_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot(lane_en));
  // R1: storage cleared while reset is held
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> !ser_out);
endmodule

// File: tb/ilv_shift_reg_bench.sv
`timescale 1ns/1ps
module ilv_shift_reg_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_in = 1'b0;
  logic out_w1, out_w2, out_w4;
  logic [15:0] ref_q = '0;
  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ilv_shift_reg #(.WAYS(2), .DEPTH(16)) u_ilv_shift_reg (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(out_w2));
  ilv_shift_reg #(.WAYS(1), .DEPTH(16)) u_ilv_shift_reg_w1 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(out_w1));
  ilv_shift_reg #(.WAYS(4), .DEPTH(16)) u_ilv_shift_reg_w4 (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_out(out_w4));

  localparam logic [31:0] PATS [8] = '{
    32'hFFFF_0000, 32'hAAAA_AAAA, 32'hCCCC_3333, 32'h8000_0001,
    32'h1234_5678, 32'hF0F0_0F0F, 32'hDEAD_BEEF, 32'h0001_8000};

  task automatic check(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ser_out=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one bit, let it be captured, compare all three variants with a plain chain.
  task automatic step(input logic b, input string extra);
    ser_in = b;
    @(posedge clk); #1;
    ref_q = {ref_q[14:0], b};
    check({"R3 ", extra}, out_w1, ref_q[15]);
    check({"R4 ", extra}, out_w2, ref_q[15]);
    check({"R5 ", extra}, out_w4, ref_q[15]);
  endtask

  // Release reset and drive ones on the two edges that must be swallowed (R2).
  task automatic release_swallow();
    ser_in = 1'b1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    ref_q = '0;
    for (int i = 0; i < 20; i++) step(1'b0, "R2");
  endtask

  initial begin
    #150000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1", out_w1, 1'b0);
    check("R1", out_w2, 1'b0);
    check("R1", out_w4, 1'b0);
    release_swallow();

    // Table of patterns, R3 R4 R5 R8
    for (int p = 0; p < 8; p++)
      for (int b = 31; b >= 0; b--) step(PATS[p][b], "R8");

    // Isolated ones at shifting phase alignments, R6 R7
    for (int a = 0; a < 6; a++) begin
      step(1'b1, "R6");
      for (int z = 0; z < 16 + a; z++) step(1'b0, "R7");
    end

    // Asynchronous clear with a full load, R1
    for (int i = 0; i < 20; i++) step(1'b1, "R1");
    #1 rst_n = 1'b0;
    #0.5;
    check("R1", out_w1, 1'b0);
    check("R1", out_w2, 1'b0);
    check("R1", out_w4, 1'b0);
    @(posedge clk); #1;
    release_swallow();
    for (int i = 0; i < 40; i++) step(i[0] ^ i[2], "R4");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule